// File: doc/BRIEF.md
# Serial NAND Programmed-I/O Transfer Engine

This block moves short bursts of bytes between a host and a serial NAND flash device under direct software control. The host sees a small set of 32-bit registers on a simple read/write bus. To send bytes, software first writes a command word that gives the byte count (1 to 4) and the number of data lanes (1, 2 or 4), then writes a left-aligned data word; the top byte leaves first. To receive bytes, software writes a read command carrying the count and lane width, waits for the busy flag to drop, and then reads a data word whose top byte holds the first byte received.

A typical flash operation is built by software from several such steps while a chip select stays low. The opcode and address go out in one single-lane burst, optional dummy cycles follow, and then the data phase runs as a sequence of bursts of up to four bytes each. The chip selects are plain software-written bits, one for each device. The serial clock runs at half the system clock and idles low. Output lanes change while the serial clock is low, and input lanes are captured on its rising edge.

Top module: `snand_pio_engine`

## Requirements
- R1: The chip-select register sits at byte offset 0x04 and reads back with bit 4*n holding chip n's select and every other bit reading 1. The write-command register at 0x08 reads back with the byte count minus one in bits 1:0, the lane code in bits 29:28, and zeros elsewhere. Lane code 0 is one lane, 1 is two lanes and 2 is four lanes.
- R2: When idle, a write to the write-data register at 0x14 starts an output burst of the programmed count and lane code. Bits are sent MSB-first starting at bit 31. On one lane the bit is driven on io_o[0]. On two lanes io_o[1] carries the more significant bit of each pair. On four lanes io_o[3:0] carry bits 31:28 of the remaining word.
- R3: When idle, a write to the read-command register at 0x0C (same field layout as 0x08) starts an input burst. One lane is sampled from io_i[1], two lanes from io_i[1:0] and four lanes from io_i[3:0], with the highest lane being the most significant. On completion, the read-data register at 0x10 holds the first received byte in bits 31:24, later bytes below it, and zeros in the unused low bytes.
- R4: sclk_o is low whenever no burst runs. During a burst it toggles every system clock cycle and gives exactly 8*count/lanes rising edges. io_o never changes on a system clock edge where sclk_o rises, and input lanes are captured at that edge.
- R5: Status bit 3 (register 0x40) is busy. It rises on the clock edge that accepts the launching write and stays high for exactly 2*8*count/lanes cycles.
- R6: Status bit 2 is high only during an input burst and status bit 1 only during an output burst. Both read 0 when idle.
- R7: Output cs_n_o[n] follows bit 4*n of the last value written to 0x04. Writing 0xFFFFFFEF selects only chip 1, and writing all ones deselects both.
- R8: Writes to 0x08, 0x0C or 0x14 while busy have no effect: the running burst is not changed or restarted, and the write-command fields are kept.
- R9: The read-data register keeps its value during any burst and through output bursts. It changes only when an input burst completes.
- R10: After reset, status reads 0, the read-data register reads 0, the chip-select register reads all ones with both chip selects high, sclk_o is low and io_oe_o is 0.
- R11: io_oe_o enables the lanes used by an output burst (0001, 0011 or 1111 for 1, 2 or 4 lanes) and is 0 during input bursts and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| sclk_o | output | 1 | Serial clock, half the system clock |
| io_o | output | 4 | Serial data lanes driven toward the flash |
| io_oe_o | output | 4 | Per-lane output enable |
| io_i | input | 4 | Serial data lanes from the flash |

## Verification
The bound checker watches, on every cycle, the serial clock idling low and toggling during bursts, the output lanes holding still across each rising serial edge, the lane enables staying off when idle or receiving, the two activity flags never being set together, the write-command fields staying frozen against writes made while busy, and the read-data register changing only when a receive finishes. Only the bench scenarios can show that bytes leave and arrive in the right order on each lane width, that unused low bytes read as zero, that busy lasts exactly the computed number of cycles, and that the chip-select bits reach the right pins. They are also the only way to show that a data write made during a burst does not restart it.

// File: rtl/snand_pio_pkg.sv
`timescale 1ns/1ps
package snand_pio_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = 4;
  localparam int CS_STEP  = 4;

  localparam int OFS_CS    = 'h04;
  localparam int OFS_WCMD  = 'h08;
  localparam int OFS_RCMD  = 'h0C;
  localparam int OFS_RDATA = 'h10;
  localparam int OFS_WDATA = 'h14;
  localparam int OFS_STAT  = 'h40;

  localparam int WID_HI = 29;
  localparam int WID_LO = 28;

  typedef struct packed {
    logic [1:0] wid;
    logic [1:0] len_m1;
  } xfer_cfg_t;

  // lane groups in a burst, minus one: 8n/1, 8n/2, 8n/4
  function automatic logic [4:0] groups_m1(xfer_cfg_t c);
    case (c.wid)
      2'd0:    return {c.len_m1, 3'b111};
      2'd1:    return {1'b0, c.len_m1, 2'b11};
      default: return {2'b00, c.len_m1, 1'b1};
    endcase
  endfunction
endpackage

// File: rtl/snand_regs.sv
`timescale 1ns/1ps
module snand_regs
  import snand_pio_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NUM_CS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              busy_i,
  input  logic              rd_act_i,
  input  logic              wr_act_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output xfer_cfg_t         wcmd_o,
  output logic              start_o,
  output logic              start_out_o,
  output xfer_cfg_t         start_cfg_o,
  output logic [DATA_W-1:0] start_data_o
);
  logic [NUM_CS-1:0] cs_q;
  xfer_cfg_t         wcmd_q;
  logic              wr_acc;
  logic              hit_cs, hit_wcmd, hit_rcmd, hit_wdata;
  logic [DATA_W-1:0] cs_word;
  xfer_cfg_t         bus_cfg;

  assign wr_acc    = bus_en_i & bus_we_i;
  assign hit_cs    = bus_addr_i == ADDR_W'(OFS_CS);
  assign hit_wcmd  = bus_addr_i == ADDR_W'(OFS_WCMD);
  assign hit_rcmd  = bus_addr_i == ADDR_W'(OFS_RCMD);
  assign hit_wdata = bus_addr_i == ADDR_W'(OFS_WDATA);
  assign bus_cfg   = '{wid: bus_wdata_i[WID_HI:WID_LO], len_m1: bus_wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '1;
      wcmd_q <= '0;
    end else if (wr_acc) begin
      if (hit_cs) begin
        for (int n = 0; n < NUM_CS; n++) cs_q[n] <= bus_wdata_i[CS_STEP*n];
      end
      if (hit_wcmd && !busy_i) wcmd_q <= bus_cfg;
    end
  end

  generate
    for (genvar n = 0; n < DATA_W; n++) begin : g_csw
      if ((n % CS_STEP == 0) && (n / CS_STEP < NUM_CS)) begin : g_sel
        assign cs_word[n] = cs_q[n/CS_STEP];
      end else begin : g_one
        assign cs_word[n] = 1'b1;
      end
    end
  endgenerate

  assign start_o      = wr_acc & ~busy_i & (hit_wdata | hit_rcmd);
  assign start_out_o  = hit_wdata;
  assign start_cfg_o  = hit_wdata ? wcmd_q : bus_cfg;
  assign start_data_o = bus_wdata_i;
  assign cs_n_o       = cs_q;
  assign wcmd_o       = wcmd_q;

  always_comb begin
    bus_rdata_o = '0;
    if (hit_cs) bus_rdata_o = cs_word;
    else if (hit_wcmd) begin
      bus_rdata_o[WID_HI:WID_LO] = wcmd_q.wid;
      bus_rdata_o[1:0]           = wcmd_q.len_m1;
    end
    else if (bus_addr_i == ADDR_W'(OFS_RDATA)) bus_rdata_o = rdata_i;
    else if (bus_addr_i == ADDR_W'(OFS_STAT))  bus_rdata_o[3:1] = {busy_i, rd_act_i, wr_act_i};
  end
endmodule

// File: rtl/snand_shifter.sv
`timescale 1ns/1ps
module snand_shifter
  import snand_pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_out_i,
  input  xfer_cfg_t         start_cfg_i,
  input  logic [DATA_W-1:0] start_data_i,
  input  logic [LANES-1:0]  io_i,
  output logic              busy_o,
  output logic              rd_act_o,
  output logic              wr_act_o,
  output logic              sclk_o,
  output logic [LANES-1:0]  io_o,
  output logic [LANES-1:0]  io_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              busy_q, out_q, sclk_q;
  xfer_cfg_t         cfg_q;
  logic [4:0]        cnt_q;
  logic [DATA_W-1:0] tx_q, rx_q, rdata_q, tx_nxt, rx_nxt;

  always_comb begin
    case (cfg_q.wid)
      2'd0: begin
        tx_nxt = {tx_q[DATA_W-2:0], 1'b0};
        rx_nxt = {rx_q[DATA_W-2:0], io_i[1]};
      end
      2'd1: begin
        tx_nxt = {tx_q[DATA_W-3:0], 2'b00};
        rx_nxt = {rx_q[DATA_W-3:0], io_i[1:0]};
      end
      default: begin
        tx_nxt = {tx_q[DATA_W-5:0], 4'b0000};
        rx_nxt = {rx_q[DATA_W-5:0], io_i};
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      out_q   <= 1'b0;
      sclk_q  <= 1'b0;
      cfg_q   <= '0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        out_q  <= start_out_i;
        cfg_q  <= start_cfg_i;
        cnt_q  <= groups_m1(start_cfg_i);
        tx_q   <= start_data_i;
        rx_q   <= '0;
      end
    end else if (!sclk_q) begin
      // rising serial edge: capture inputs
      sclk_q <= 1'b1;
      if (!out_q) rx_q <= rx_nxt;
    end else begin
      // falling serial edge: advance outputs or finish
      sclk_q <= 1'b0;
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        if (!out_q) rdata_q <= rx_q << {~cfg_q.len_m1, 3'b000};
      end else begin
        cnt_q <= cnt_q - 5'd1;
        tx_q  <= tx_nxt;
      end
    end
  end

  always_comb begin
    io_o    = '0;
    io_oe_o = '0;
    if (busy_q && out_q) begin
      case (cfg_q.wid)
        2'd0:    begin io_o = {3'b000, tx_q[DATA_W-1]};      io_oe_o = 4'b0001; end
        2'd1:    begin io_o = {2'b00, tx_q[DATA_W-1 -: 2]};  io_oe_o = 4'b0011; end
        default: begin io_o = tx_q[DATA_W-1 -: 4];           io_oe_o = 4'b1111; end
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign rd_act_o = busy_q & ~out_q;
  assign wr_act_o = busy_q & out_q;
  assign sclk_o   = sclk_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/snand_pio_engine.sv
`timescale 1ns/1ps
module snand_pio_engine
  import snand_pio_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NUM_CS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              sclk_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  input  logic [3:0]        io_i
);
  logic              busy, rd_act, wr_act;
  logic              start, start_out;
  xfer_cfg_t         start_cfg, wcmd;
  logic [DATA_W-1:0] start_data, rdata;

  snand_regs #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .busy_i      (busy),
    .rd_act_i    (rd_act),
    .wr_act_i    (wr_act),
    .rdata_i     (rdata),
    .cs_n_o      (cs_n_o),
    .wcmd_o      (wcmd),
    .start_o     (start),
    .start_out_o (start_out),
    .start_cfg_o (start_cfg),
    .start_data_o(start_data)
  );

  snand_shifter shift_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_out_i (start_out),
    .start_cfg_i (start_cfg),
    .start_data_i(start_data),
    .io_i        (io_i),
    .busy_o      (busy),
    .rd_act_o    (rd_act),
    .wr_act_o    (wr_act),
    .sclk_o      (sclk_o),
    .io_o        (io_o),
    .io_oe_o     (io_oe_o),
    .rdata_o     (rdata)
  );
endmodule

// File: rtl/snand_pio_chk.sv
`timescale 1ns/1ps
module snand_pio_chk
  import snand_pio_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        sclk_i,
  input logic [3:0]  io_i,
  input logic [3:0]  oe_i,
  input logic        rd_act_i,
  input logic        wr_act_i,
  input xfer_cfg_t   wcmd_i,
  input logic        bus_en_i,
  input logic        bus_we_i,
  input logic [31:0] rdata_i
);
  // R4
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i);
  // R4
  sclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> (sclk_i != $past(sclk_i)));
  // R4
  io_hold_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_i) |-> $stable(io_i));
  // R5
  busy_start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !sclk_i);
  // R11
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i || rd_act_i) |-> (oe_i == 4'b0000));
  // R6
  act_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_act_i, wr_act_i}));
  // R8
  wcmd_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && bus_en_i && bus_we_i) |=> $stable(wcmd_i));
  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_i) |-> $past(rd_act_i));
endmodule

bind snand_pio_engine snand_pio_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .sclk_i  (sclk_o),
  .io_i    (io_o),
  .oe_i    (io_oe_o),
  .rd_act_i(rd_act),
  .wr_act_i(wr_act),
  .wcmd_i  (wcmd),
  .bus_en_i(bus_en_i),
  .bus_we_i(bus_we_i),
  .rdata_i (rdata)
);

// File: tb/snand_pio_engine_tb_top.sv
`timescale 1ns/1ps
module snand_pio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  cs_n;
  logic        sclk;
  logic [3:0]  io_out, io_oe, io_in;

  int checks = 0, errors = 0;
  int rise_cnt = 0, rx_base = 0;
  logic [1:0]  cur_wid = 2'd0;
  logic [31:0] rx_pat = '0, tx_cap = '0, prev_rd = '0;

  always #2.5 clk = ~clk;

  snand_pio_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cs_n_o(cs_n), .sclk_o(sclk),
    .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in)
  );

  function automatic int lanes(logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  // flash model: capture outputs and count rising serial edges
  always @(posedge sclk) begin
    case (cur_wid)
      2'd0:    tx_cap = {tx_cap[30:0], io_out[0]};
      2'd1:    tx_cap = {tx_cap[29:0], io_out[1:0]};
      default: tx_cap = {tx_cap[27:0], io_out};
    endcase
    rise_cnt = rise_cnt + 1;
  end

  always_comb begin
    logic [31:0] g;
    int k;
    k = (rise_cnt - rx_base) * lanes(cur_wid);
    g = (k < 32) ? (rx_pat << k) : 32'd0;
    case (cur_wid)
      2'd0:    io_in = {2'b00, g[31], 1'b0};
      2'd1:    io_in = {2'b00, g[31:30]};
      default: io_in = g[31:28];
    endcase
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // encoding: [36] 1=output, [35:34] lane code, [33:32] count-1, [31:0] data or pattern
  localparam logic [36:0] VEC [9] = '{
    {1'b1, 2'd0, 2'd0, 32'h13A5C7E9},
    {1'b1, 2'd0, 2'd3, 32'h0F1E2D3C},
    {1'b1, 2'd1, 2'd1, 32'h9C3B7711},
    {1'b1, 2'd2, 2'd2, 32'h5AA55A66},
    {1'b1, 2'd2, 2'd3, 32'hDEADBEEF},
    {1'b0, 2'd0, 2'd1, 32'hC3E1AAAA},
    {1'b0, 2'd1, 2'd3, 32'h12345678},
    {1'b0, 2'd2, 2'd0, 32'hB7654321},
    {1'b0, 2'd2, 2'd2, 32'h8F70E1D2}
  };

  task automatic run_xfer(input logic [36:0] v);
    logic        is_out;
    logic [1:0]  w, l;
    logic [31:0] d, cmd, r, exp;
    int n, grp, cyc, base;
    is_out = v[36]; w = v[35:34]; l = v[33:32]; d = v[31:0];
    n = int'(l) + 1;
    grp = 8 * n / lanes(w);
    cmd = {2'b00, w, 26'd0, l};
    cur_wid = w; rx_pat = d; rx_base = rise_cnt; base = rise_cnt;
    if (is_out) begin
      bus_write(7'h08, cmd);
      bus_write(7'h14, d);
    end else begin
      bus_write(7'h0C, cmd);
    end
    bus_read(7'h10, r);
    check("R9 read data held during burst", r, prev_rd);
    bus_read(7'h40, r);
    check("R6 activity flags", r, is_out ? 32'h0000000A : 32'h0000000C);
    exp = is_out ? ((w == 2'd0) ? 32'h1 : (w == 2'd1) ? 32'h3 : 32'hF) : 32'h0;
    check("R11 lane enables", {28'd0, io_oe}, exp);
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      bus_read(7'h40, r);
      if (!r[3]) break;
      cyc++;
      @(negedge clk);
    end
    check("R5 busy length", cyc, 2 * grp);
    check("R4 serial rising edges", rise_cnt - base, grp);
    check("R4 sclk idle low", {31'd0, sclk}, 32'd0);
    bus_read(7'h40, r);
    check("R6 idle status", r, 32'd0);
    if (is_out) begin
      check("R2 transmitted bytes", (n == 4) ? tx_cap : (tx_cap & ((32'd1 << (8*n)) - 1)),
            d >> (32 - 8*n));
      bus_read(7'h10, r);
      check("R9 read data kept over output burst", r, prev_rd);
    end else begin
      exp = d & ~(32'hFFFFFFFF >> (8*n));
      bus_read(7'h10, r);
      check("R3 received word", r, exp);
      prev_rd = exp;
    end
  endtask

  initial begin
    logic [31:0] r;
    int base;
    repeat (3) @(negedge clk);
    // R10 reset state
    bus_read(7'h40, r); check("R10 status", r, 32'd0);
    bus_read(7'h10, r); check("R10 read data", r, 32'd0);
    bus_read(7'h04, r); check("R10 cs register", r, 32'hFFFFFFFF);
    check("R10 pins", {26'd0, cs_n, sclk, io_oe}, {26'd0, 2'b11, 1'b0, 4'b0000});
    rst_n = 1'b1;
    @(negedge clk);

    // R1 readback
    bus_write(7'h08, 32'h20000002);
    bus_read(7'h08, r); check("R1 write command readback", r, 32'h20000002);
    bus_write(7'h08, 32'hDFFFFFFD);
    bus_read(7'h08, r); check("R1 write command fields only", r, 32'h10000001);
    // R7 chip selects
    bus_write(7'h04, 32'hFFFFFFEF);
    check("R7 chip 1 selected", {30'd0, cs_n}, 32'h1);
    bus_read(7'h04, r); check("R1 cs readback", r, 32'hFFFFFFEF);
    bus_write(7'h04, 32'hFFFFFFFE);
    check("R7 chip 0 selected", {30'd0, cs_n}, 32'h2);
    bus_write(7'h04, 32'hFFFFFFFF);
    check("R7 all deselected", {30'd0, cs_n}, 32'h3);

    foreach (VEC[i]) run_xfer(VEC[i]);

    // R8 writes while busy are ignored
    cur_wid = 2'd0; base = rise_cnt;
    bus_write(7'h08, 32'h00000003);
    bus_write(7'h14, 32'h8E3D1F6B);
    bus_write(7'h08, 32'h20000000);
    bus_write(7'h14, 32'hFFFFFFFF);
    bus_write(7'h0C, 32'h20000003);
    repeat (80) @(negedge clk);
    check("R8 burst not restarted", rise_cnt - base, 32);
    check("R8 burst data unchanged", tx_cap, 32'h8E3D1F6B);
    bus_read(7'h08, r); check("R8 command kept", r, 32'h00000003);
    bus_read(7'h40, r); check("R8 idle after", r, 32'd0);
    bus_read(7'h10, r); check("R8 no read launched", r, prev_rd);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule